// File: doc/BRIEF.md
# Load/Store Data Alignment Unit

This unit sits between a 32-bit register datapath and a word-wide data memory. Each cycle it takes a base register value and a 16-bit signed displacement and forms the effective address. From that address it derives the word address sent to memory and the byte lane that is being accessed. Memory is big-endian: the lowest byte address inside a word maps to the most significant byte of that word.

For loads, the unit picks the addressed byte, halfword or word out of the word read from memory and widens it to 32 bits. Byte and halfword values are sign- or zero-extended, chosen by a flag. For stores, it copies the low byte, the low halfword or the whole source register onto every lane of the write word. It then raises only the byte enables of the lanes that are really written.

If an access does not sit on its natural boundary, the unit flags it and performs nothing. All outputs are registered and appear one clock after the inputs.

Top module: `ldst_align`

## Requirements
- R1: One clock after the inputs, `word_addr` equals (base_addr + offset sign-extended to 32 bits) modulo 2^32, with its two low bits forced to zero.
- R2: `acc_size` encoding is 0 = byte, 1 = halfword, 2 or 3 = word. Big-endian lanes: effective-address low bits 0, 1, 2 and 3 select `rd_word` bits 31..24, 23..16, 15..8 and 7..0. A halfword at low bits 0 uses bits 31..16, and one at low bits 2 uses bits 15..0.
- R3: A byte or halfword load with `sign_ext` = 1 returns the selected field with its top bit copied into all higher bits of `load_data`.
- R4: A byte or halfword load with `sign_ext` = 0 returns the selected field with all higher bits of `load_data` zero.
- R5: A word load returns `rd_word` unchanged, whatever `sign_ext` is.
- R6: `wr_data` holds `store_src[7:0]` on all four lanes for a byte access. For a halfword access it holds `store_src[15:0]` in both halves, and for a word access it holds `store_src` itself.
- R7: `byte_en` bit j covers `wr_data` bits 8j+7..8j. An aligned byte store sets only bit 3 - (low address bits). An aligned halfword store sets bits 3..2 at offset 0 or bits 1..0 at offset 2. An aligned word store sets all four bits.
- R8: `misaligned` is 1 for a halfword access with address bit 0 set, and for a word access with either of the two low address bits set. It is 0 otherwise. When it is 1, `byte_en` is 0 and `load_data` is 0.
- R9: When `is_store` is 0, `byte_en` is 0.
- R10: A synchronous active-high `rst` clears every output at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_addr | input | 32 | Base register value |
| offset | input | 16 | Signed address displacement |
| acc_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| sign_ext | input | 1 | 1 = sign-extend loaded byte/halfword, 0 = zero-extend |
| is_store | input | 1 | 1 = store access, 0 = load access |
| store_src | input | 32 | Register data to be stored |
| rd_word | input | 32 | Word read from memory at the current word address |
| word_addr | output | 32 | Word-aligned address to memory (registered) |
| wr_data | output | 32 | Lane-replicated write data (registered) |
| byte_en | output | 4 | Per-lane write enables, bit j for bits 8j+7..8j (registered) |
| load_data | output | 32 | Extracted and extended load result (registered) |
| misaligned | output | 1 | Access is not on its natural boundary (registered) |

## Verification
The assertions check four properties on every cycle after reset: the word address against the inputs of the cycle before, the silence of the enables for loads and for misaligned accesses, the single enable of a byte store, and the zero top bits of an unsigned byte load. Lane choice is not covered by any property, because only the bench's scenarios can show it. The bench sweeps every size code, every low-address offset, both extension modes and both directions over data patterns with set and clear top bits. That sweep shows the correct lane is picked for loads, the exact enable mask for stores and the replication of the store data. Reset clearing and the wrap-around of negative displacements are shown by directed cases.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2,
    ACC_WRD2 = 2'd3
  } acc_size_e;
endpackage

// File: rtl/ldst_agu.sv
module ldst_agu
  import ldst_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16,
  parameter int LANE_W = 2
) (
  input  logic [DATA_W-1:0] base_addr,
  input  logic [OFF_W-1:0]  offset,
  input  acc_size_e         acc_size,
  output logic [DATA_W-1:0] eff_addr,
  output logic [LANE_W-1:0] lane,
  output logic              misaligned
);
  localparam int EXT_W = DATA_W - OFF_W;

  assign eff_addr = base_addr + {{EXT_W{offset[OFF_W-1]}}, offset};
  assign lane     = eff_addr[LANE_W-1:0];

  always_comb begin
    unique case (acc_size)
      ACC_BYTE: misaligned = 1'b0;
      ACC_HALF: misaligned = lane[0];
      default:  misaligned = |lane;
    endcase
  end
endmodule

// File: rtl/ldst_load_ext.sv
module ldst_load_ext
  import ldst_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 2
) (
  input  logic [DATA_W-1:0] rd_word,
  input  logic [LANE_W-1:0] lane,
  input  acc_size_e         acc_size,
  input  logic              sign_ext,
  output logic [DATA_W-1:0] result
);
  localparam int SH_W = LANE_W + 3;

  // Big-endian: lane k sits (LANES-1-k) bytes above bit 0, i.e. ~lane bytes.
  logic [SH_W-1:0]   byte_sh, half_sh;
  logic [DATA_W-1:0] byte_pos, half_pos;
  logic [7:0]        byte_v;
  logic [15:0]       half_v;

  assign byte_sh  = {~lane, 3'b000};
  assign half_sh  = {~lane[LANE_W-1:1], 4'b0000};
  assign byte_pos = rd_word >> byte_sh;
  assign half_pos = rd_word >> half_sh;
  assign byte_v   = byte_pos[7:0];
  assign half_v   = half_pos[15:0];

  always_comb begin
    unique case (acc_size)
      ACC_BYTE: result = {{(DATA_W-8){sign_ext & byte_v[7]}}, byte_v};
      ACC_HALF: result = {{(DATA_W-16){sign_ext & half_v[15]}}, half_v};
      default:  result = rd_word;
    endcase
  end
endmodule

// File: rtl/ldst_store_steer.sv
module ldst_store_steer
  import ldst_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 2
) (
  input  logic [DATA_W-1:0]   store_src,
  input  logic [LANE_W-1:0]   lane,
  input  acc_size_e           acc_size,
  output logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W/8-1:0] lane_mask
);
  localparam int LANES = DATA_W / 8;

  logic [LANE_W-1:0] half_pos;
  assign half_pos = {~lane[LANE_W-1:1], 1'b0};

  always_comb begin
    unique case (acc_size)
      ACC_BYTE: begin
        wr_data   = {LANES{store_src[7:0]}};
        lane_mask = LANES'(1) << ~lane;
      end
      ACC_HALF: begin
        wr_data   = {(LANES/2){store_src[15:0]}};
        lane_mask = LANES'(3) << half_pos;
      end
      default: begin
        wr_data   = store_src;
        lane_mask = {LANES{1'b1}};
      end
    endcase
  end
endmodule

// File: rtl/ldst_align.sv
module ldst_align
  import ldst_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [DATA_W-1:0]   base_addr,
  input  logic [OFF_W-1:0]    offset,
  input  logic [1:0]          acc_size,
  input  logic                sign_ext,
  input  logic                is_store,
  input  logic [DATA_W-1:0]   store_src,
  input  logic [DATA_W-1:0]   rd_word,
  output logic [DATA_W-1:0]   word_addr,
  output logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W/8-1:0] byte_en,
  output logic [DATA_W-1:0]   load_data,
  output logic                misaligned
);
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);

  acc_size_e         size_e;
  logic [DATA_W-1:0] eff_addr, ext_res, steer_data;
  logic [LANE_W-1:0] lane;
  logic              mis_c;
  logic [LANES-1:0]  mask_c;

  assign size_e = acc_size_e'(acc_size);

  ldst_agu #(.DATA_W(DATA_W), .OFF_W(OFF_W), .LANE_W(LANE_W)) u_agu (
    .base_addr (base_addr),
    .offset    (offset),
    .acc_size  (size_e),
    .eff_addr  (eff_addr),
    .lane      (lane),
    .misaligned(mis_c)
  );

  ldst_load_ext #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_ext (
    .rd_word (rd_word),
    .lane    (lane),
    .acc_size(size_e),
    .sign_ext(sign_ext),
    .result  (ext_res)
  );

  ldst_store_steer #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_steer (
    .store_src(store_src),
    .lane     (lane),
    .acc_size (size_e),
    .wr_data  (steer_data),
    .lane_mask(mask_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      word_addr  <= '0;
      wr_data    <= '0;
      byte_en    <= '0;
      load_data  <= '0;
      misaligned <= 1'b0;
    end else begin
      word_addr  <= {eff_addr[DATA_W-1:LANE_W], {LANE_W{1'b0}}};
      wr_data    <= steer_data;
      byte_en    <= (is_store && !mis_c) ? mask_c : '0;
      load_data  <= mis_c ? '0 : ext_res;
      misaligned <= mis_c;
    end
  end
endmodule

// File: rtl/ldst_align_chk.sv
module ldst_align_chk #(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16
) (
  input logic                clk,
  input logic                rst,
  input logic [DATA_W-1:0]   base_addr,
  input logic [OFF_W-1:0]    offset,
  input logic [1:0]          acc_size,
  input logic                sign_ext,
  input logic                is_store,
  input logic [DATA_W-1:0]   word_addr,
  input logic [DATA_W/8-1:0] byte_en,
  input logic [DATA_W-1:0]   load_data,
  input logic                misaligned
);
  logic              armed;
  logic [DATA_W-1:0] ea_now;

  assign ea_now = base_addr + {{(DATA_W-OFF_W){offset[OFF_W-1]}}, offset};

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  p_word_addr_r1: assert property (@(posedge clk) disable iff (rst)
    armed |-> (word_addr == ($past(ea_now) & ~DATA_W'(3))));

  p_load_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(is_store)) |-> (byte_en == '0));

  p_mis_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (armed && misaligned) |-> (byte_en == '0 && load_data == '0));

  p_byte_one_lane_r7: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(is_store) && $past(acc_size) == 2'd0) |-> ($countones(byte_en) == 1));

  p_ubyte_zero_top_r4: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(is_store) && $past(acc_size) == 2'd0 && !$past(sign_ext))
      |-> (load_data[DATA_W-1:8] == '0));
endmodule

bind ldst_align ldst_align_chk #(.DATA_W(DATA_W), .OFF_W(OFF_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .base_addr (base_addr),
  .offset    (offset),
  .acc_size  (acc_size),
  .sign_ext  (sign_ext),
  .is_store  (is_store),
  .word_addr (word_addr),
  .byte_en   (byte_en),
  .load_data (load_data),
  .misaligned(misaligned)
);

// File: tb/test_ldst_align.sv
`timescale 1ns/1ps
module test_ldst_align;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] base_addr, store_src, rd_word;
  logic [15:0] offset;
  logic [1:0]  acc_size;
  logic        sign_ext, is_store;
  logic [31:0] word_addr, wr_data, load_data;
  logic [3:0]  byte_en;
  logic        misaligned;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ldst_align i_ldst_align (
    .clk(clk), .rst(rst), .base_addr(base_addr), .offset(offset),
    .acc_size(acc_size), .sign_ext(sign_ext), .is_store(is_store),
    .store_src(store_src), .rd_word(rd_word), .word_addr(word_addr),
    .wr_data(wr_data), .byte_en(byte_en), .load_data(load_data),
    .misaligned(misaligned)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [31:0] b, input logic [15:0] o, input logic [1:0] sz,
                       input logic sg, input logic st, input logic [31:0] src,
                       input logic [31:0] rd);
    @(negedge clk);
    base_addr = b; offset = o; acc_size = sz; sign_ext = sg;
    is_store = st; store_src = src; rd_word = rd;
    @(negedge clk);
  endtask

  task automatic run_case(input logic [31:0] b, input logic [15:0] o, input logic [1:0] sz,
                          input logic sg, input logic st, input logic [31:0] src,
                          input logic [31:0] rd);
    longint ea;
    int ln, fw, sh;
    longint fld, expl, expw;
    logic mis;
    logic [3:0] exp_be;
    ea = (longint'(b) + (o >= 16'h8000 ? longint'(o) - 65536 : longint'(o))) % 64'h1_0000_0000;
    if (ea < 0) ea += 64'h1_0000_0000;
    ln  = int'(ea % 4);
    mis = (sz == 2'd1) ? (ln % 2 == 1) : (sz >= 2'd2) ? (ln != 0) : 1'b0;
    apply(b, o, sz, sg, st, src, rd);
    chk("R1 word_addr", word_addr, 32'(ea - ln));
    chk("R8 misaligned", {31'd0, misaligned}, {31'd0, mis});
    if (sz == 2'd0) begin fw = 8;  sh = 8 * (3 - ln); end
    else if (sz == 2'd1) begin fw = 16; sh = 8 * (2 - (ln / 2) * 2); end
    else begin fw = 32; sh = 0; end
    if (!st) begin
      fld = (longint'(rd) / (64'd1 << sh)) % (64'd1 << fw);
      expl = fld;
      if (sg && fw < 32 && fld >= (64'd1 << (fw - 1))) expl = fld + 64'h1_0000_0000 - (64'd1 << fw);
      if (mis) expl = 0;
      if (sz >= 2'd2)      chk("R5 word load", load_data, 32'(expl));
      else if (mis)        chk("R8 mis load zero", load_data, 32'(expl));
      else if (sg)         chk("R3 signed load", load_data, 32'(expl));
      else                 chk("R4 unsigned load", load_data, 32'(expl));
      chk("R9 load enables", {28'd0, byte_en}, 32'd0);
    end else begin
      if (sz == 2'd0)      expw = (longint'(src) % 256) * 64'h0101_0101;
      else if (sz == 2'd1) expw = (longint'(src) % 65536) * 64'h0001_0001;
      else                 expw = longint'(src);
      chk("R6 store data", wr_data, 32'(expw));
      if (mis)             exp_be = 4'd0;
      else if (sz == 2'd0) exp_be = 4'(1 << (3 - ln));
      else if (sz == 2'd1) exp_be = 4'(3 << (2 - ln));
      else                 exp_be = 4'hF;
      chk(mis ? "R8 mis enables" : "R7 store enables", {28'd0, byte_en}, {28'd0, exp_be});
    end
  endtask

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'h80F1_7F01; pats[1] = 32'h7F80_FF00;
    pats[2] = 32'hA5C3_3C5A; pats[3] = 32'h0123_89AB;
    base_addr = 32'hFFFF_FFFF; offset = 16'hFFFF; acc_size = 2'd2; sign_ext = 1'b1;
    is_store = 1'b1; store_src = 32'hFFFF_FFFF; rd_word = 32'hFFFF_FFFF;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 reset word_addr", word_addr, 32'd0);
    chk("R10 reset wr_data", wr_data, 32'd0);
    chk("R10 reset byte_en", {28'd0, byte_en}, 32'd0);
    chk("R10 reset load_data", load_data, 32'd0);
    chk("R10 reset misaligned", {31'd0, misaligned}, 32'd0);
    rst = 1'b0;
    // R2 sweep: every size code, lane offset, extension mode, direction, pattern
    for (int sz = 0; sz < 4; sz++)
      for (int ln = 0; ln < 4; ln++)
        for (int sg = 0; sg < 2; sg++)
          for (int st = 0; st < 2; st++)
            for (int p = 0; p < 4; p++)
              run_case(32'h0000_1000 + 32'(ln) + 32'(p * 64), 16'h0000, 2'(sz),
                       1'(sg), 1'(st), pats[(p + 1) % 4], pats[p]);
    // R1 displacement: negative, positive, wrap both ways
    run_case(32'h0000_2003, 16'hFFFD, 2'd2, 1'b0, 1'b0, 32'd0, 32'hDEAD_BEEF);
    run_case(32'h0000_0001, 16'hFFFE, 2'd0, 1'b1, 1'b0, 32'd0, 32'h0000_0080);
    run_case(32'hFFFF_FFFE, 16'h0005, 2'd1, 1'b1, 1'b1, 32'h1234_5678, 32'd0);
    run_case(32'h1234_5670, 16'h7FFF, 2'd0, 1'b0, 1'b1, 32'h0000_00C3, 32'd0);
    run_case(32'h1234_5670, 16'h8000, 2'd1, 1'b1, 1'b0, 32'd0, 32'h8001_7FFE);
    // R10 mid-run reset
    @(negedge clk);
    base_addr = 32'h0000_3000; offset = 16'd1; acc_size = 2'd0; is_store = 1'b1; rst = 1'b1;
    @(negedge clk);
    chk("R10 mid reset byte_en", {28'd0, byte_en}, 32'd0);
    chk("R10 mid reset word_addr", word_addr, 32'd0);
    rst = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule